// File: doc/BRIEF.md
# Output Fault Status Capture Controller

This controller sequences the per-channel fault check of an eight-channel constant-current sink driver while the driver runs in its extended command mode. With the outputs enabled (active-low enable input held low), the host shifts a five-bit command on the serial data line. The command picks a check for open loads or a check for shorted loads. From the fifth serial clock edge on, the controller tells the existing shift register to take its input from a parallel fault status word instead of the serial line. It also forces the sink current to its lowest range and starts a settling timer that runs on the system clock.

Once the timer has expired, every rising serial clock edge that arrives with the data line low produces a one-cycle load strobe and captures a fresh status word. The status word is built from eight comparator flags: a 0 marks a faulty channel and a 1 a healthy one. When the enable input is raised, detection ends and the source select falls back to the serial line. The captured word stays in place so the shift path can move it out while new data moves in.

The serial clock, serial data and enable inputs are asynchronous. They pass through two-flop synchronisers before any edge is detected.

Top module: `fault_capture_ctrl`

## Requirements
- R1: After reset the detection type is none (code 0), the source select, load strobe and minimum-current outputs are 0, and the status word is all ones.
- R2: Commands are collected only while the special-mode input is 1 and the enable input is 0. With special mode at 0, serial clock edges change none of the outputs.
- R3: The five data bits sampled on the first five rising serial clock edges after arming, all low, select open detection: detection type code 1, source select 1.
- R4: The command sequence low, low, high, low, low (first bit first) selects short detection: detection type code 2, source select 1.
- R5: Any other five-bit command leaves the detection type at none. Further serial edges do not start detection until the controller is disarmed and re-armed.
- R6: A load request (rising serial clock edge with data low) that arrives before SETTLE_CYCLES system clocks have passed since the fifth edge is ignored. No strobe is issued and the status word does not change.
- R7: After settling, each rising serial clock edge with data low gives exactly one single-cycle load strobe. An edge with data high gives none.
- R8: On a load, each bit of the status word is the inverse of the matching comparator flag, where a flag of 1 means a fault on that channel (status 0 = faulty, 1 = normal).
- R9: Making the enable input 1 or special mode 0 ends detection: detection type none and source select 0. The status word keeps its last captured value.
- R10: The minimum-current output is 1 exactly while a detection type other than none is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_din | input | 1 | Serial data input (asynchronous) |
| drive_en_n | input | 1 | Active-low output enable (asynchronous) |
| special_mode | input | 1 | Extended command mode is active |
| fault_flags | input | 8 | Per-channel comparator flags, 1 = fault |
| src_parallel | output | 1 | Shift register input source: 1 = status word, 0 = serial line |
| load_strobe | output | 1 | One-cycle parallel load pulse |
| det_type | output | 2 | 0 none, 1 open detection, 2 short detection |
| min_current | output | 1 | Forces the sink current to its lowest setting |
| status_word | output | 8 | Last captured fault status, 0 = faulty channel |

## Verification
All 32 five-bit commands are tried. This separates the all-low open command and the single-high-in-the-middle short command from their nearest neighbours, which differ by one bit. Each valid command is then given an early load request, which separates a working settling timer from an absent one. After settling, a high-data edge and a low-data edge separate the load condition from a plain clock edge. The fault flags change with every command, and a walking-one pass checks each bit position and the inversion. Commands sent with special mode off and extra edges after an invalid command confirm that the controller stays idle in those cases.

// File: rtl/fault_capture_pkg.sv
package fault_capture_pkg;
  localparam int CMD_LEN = 5;
  localparam int CHANNELS = 8;

  typedef enum logic [1:0] {
    DET_NONE  = 2'd0,
    DET_OPEN  = 2'd1,
    DET_SHORT = 2'd2
  } det_kind_t;

  // First serial bit lands in the MSB of the command word.
  function automatic det_kind_t decode_cmd(input logic [CMD_LEN-1:0] cmd);
    if (cmd == '0) return DET_OPEN;
    if (cmd == CMD_LEN'(1 << (CMD_LEN / 2))) return DET_SHORT;
    return DET_NONE;
  endfunction

  function automatic logic [CHANNELS-1:0] status_of(input logic [CHANNELS-1:0] flags);
    return ~flags;
  endfunction
endpackage

// File: rtl/fsc_sync.sv
module fsc_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RESET_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RESET_VAL;
      q    <= RESET_VAL;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/fsc_cmd_collect.sv
module fsc_cmd_collect #(
  parameter int LEN = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           armed,
  input  logic           edge_rise,
  input  logic           din,
  output logic           cmd_done,
  output logic [LEN-1:0] cmd_word
);
  localparam int CW = $clog2(LEN + 1);
  logic [CW-1:0]  count;
  logic [LEN-2:0] bits;

  assign cmd_done = armed && edge_rise && (count == CW'(LEN - 1));
  assign cmd_word = {bits, din};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      bits  <= '0;
    end else if (!armed) begin
      count <= '0;
      bits  <= '0;
    end else if (edge_rise && count < CW'(LEN)) begin
      count <= count + 1'b1;
      bits  <= {bits[LEN-3:0], din};
    end
  end

  a_r5_count_saturates: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(LEN));
endmodule

// File: rtl/fsc_settle_timer.sv
module fsc_settle_timer #(
  parameter int LIMIT = 700
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic clear,
  output logic settled
);
  localparam int TW = $clog2(LIMIT + 1);
  logic [TW-1:0] count;
  logic          running;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count   <= '0;
      running <= 1'b0;
    end else if (clear) begin
      count   <= '0;
      running <= 1'b0;
    end else if (start) begin
      count   <= '0;
      running <= 1'b1;
    end else if (running && count != TW'(LIMIT)) begin
      count <= count + 1'b1;
    end
  end

  assign settled = running && (count == TW'(LIMIT));

  a_r6_not_settled_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !settled);
endmodule

// File: rtl/fault_capture_ctrl.sv
module fault_capture_ctrl
  import fault_capture_pkg::*;
#(
  parameter int SETTLE_CYCLES = 700
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ser_clk,
  input  logic                ser_din,
  input  logic                drive_en_n,
  input  logic                special_mode,
  input  logic [CHANNELS-1:0] fault_flags,
  output logic                src_parallel,
  output logic                load_strobe,
  output logic [1:0]          det_type,
  output logic                min_current,
  output logic [CHANNELS-1:0] status_word
);
  logic [2:0] sync_q;
  logic       ck_s, din_s, en_n_s, ck_d;
  logic       armed, edge_rise, cmd_done, settled, load_fire;
  logic [CMD_LEN-1:0] cmd_word;
  det_kind_t  det_q, det_new;

  fsc_sync #(.W(3), .RESET_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({drive_en_n, ser_din, ser_clk}), .q(sync_q));

  assign {en_n_s, din_s, ck_s} = sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ck_d <= 1'b0;
    else        ck_d <= ck_s;
  end

  assign edge_rise = ck_s && !ck_d;
  assign armed     = special_mode && !en_n_s;

  fsc_cmd_collect #(.LEN(CMD_LEN)) u_cmd (
    .clk(clk), .rst_n(rst_n), .armed(armed), .edge_rise(edge_rise),
    .din(din_s), .cmd_done(cmd_done), .cmd_word(cmd_word));

  assign det_new = decode_cmd(cmd_word);

  fsc_settle_timer #(.LIMIT(SETTLE_CYCLES)) u_timer (
    .clk(clk), .rst_n(rst_n),
    .start(cmd_done && det_new != DET_NONE),
    .clear(!armed), .settled(settled));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        det_q <= DET_NONE;
    else if (!armed)   det_q <= DET_NONE;
    else if (cmd_done) det_q <= det_new;
  end

  assign load_fire = armed && (det_q != DET_NONE) && settled && edge_rise && !din_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_strobe <= 1'b0;
      status_word <= '1;
    end else begin
      load_strobe <= load_fire;
      if (load_fire) status_word <= status_of(fault_flags);
    end
  end

  assign det_type     = det_q;
  assign src_parallel = (det_q != DET_NONE);
  assign min_current  = (det_q != DET_NONE);

  a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
    load_strobe |=> !load_strobe);
  a_r6_strobe_after_settle: assert property (@(posedge clk) disable iff (!rst_n)
    load_fire |-> settled);
  a_r7_strobe_in_detection: assert property (@(posedge clk) disable iff (!rst_n)
    load_strobe |-> $past(src_parallel));
  a_r8_status_inverted: assert property (@(posedge clk) disable iff (!rst_n)
    load_strobe |-> status_word == ~$past(fault_flags));
  a_r9_disarm_ends: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |=> (!src_parallel && det_type == 2'd0));
  a_r9_status_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !load_strobe |-> $stable(status_word));
  a_r10_min_current: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(min_current) |-> det_type != 2'd0);
endmodule

// File: tb/fault_capture_ctrl_test.sv
module fault_capture_ctrl_test;
  localparam int SETTLE = 40;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_din = 1'b1, drive_en_n = 1'b1, special_mode = 1'b0;
  logic [7:0] fault_flags = 8'h00;
  logic src_parallel, load_strobe, min_current;
  logic [1:0] det_type;
  logic [7:0] status_word;

  int n_checks = 0;
  int n_fail = 0;
  int strobes = 0;
  logic [7:0] exp_status = 8'hFF;

  always #2.5 clk = ~clk;

  fault_capture_ctrl #(.SETTLE_CYCLES(SETTLE)) uut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .drive_en_n(drive_en_n), .special_mode(special_mode), .fault_flags(fault_flags),
    .src_parallel(src_parallel), .load_strobe(load_strobe), .det_type(det_type),
    .min_current(min_current), .status_word(status_word));

  always @(negedge clk) if (rst_n && load_strobe) strobes++;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulse(input logic b);
    @(negedge clk); ser_din = b;
    waitc(4); ser_clk = 1'b1;
    waitc(6); ser_clk = 1'b0;
    waitc(4);
  endtask

  task automatic send_cmd(input logic [4:0] p);
    for (int i = 4; i >= 0; i--) pulse(p[i]);
  endtask

  function automatic int exp_det(input logic [4:0] p);
    if (p == 5'd0) return 1;
    if (p == 5'b00100) return 2;
    return 0;
  endfunction

  task automatic check_idle(input string req);
    check({req, " det"}, det_type, 0);
    check({req, " src"}, src_parallel, 0);
    check({req, " min"}, min_current, 0);
  endtask

  task automatic run_cmd(input logic [4:0] p, input logic [7:0] flags);
    int ed, s0;
    fault_flags = flags;
    special_mode = 1'b1;
    drive_en_n = 1'b0;
    waitc(6);
    send_cmd(p);
    ed = exp_det(p);
    check(ed == 1 ? "R3 det" : (ed == 2 ? "R4 det" : "R5 det"), det_type, ed);
    check("R3/R4 src", src_parallel, ed != 0);
    check("R10 min", min_current, ed != 0);
    if (ed != 0) begin
      s0 = strobes;
      pulse(1'b0);
      check("R6 early strobe", strobes - s0, 0);
      check("R6 early status", status_word, exp_status);
      waitc(SETTLE + 20);
      s0 = strobes;
      pulse(1'b1);
      check("R7 high-data edge", strobes - s0, 0);
      pulse(1'b0);
      check("R7 one strobe", strobes - s0, 1);
      exp_status = ~flags;
      check("R8 status", status_word, exp_status);
      check("R10 min during", min_current, 1);
    end else begin
      send_cmd(5'd0);
      check("R5 no late start", det_type, 0);
      check("R5 src", src_parallel, 0);
    end
    drive_en_n = 1'b1;
    waitc(6);
    check_idle("R9");
    check("R9 status held", status_word, exp_status);
  endtask

  initial begin
    fork
      begin
        waitc(190000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
      end
    join_none
    waitc(3);
    rst_n = 1'b1;
    waitc(3);
    check_idle("R1");
    check("R1 strobe", load_strobe, 0);
    check("R1 status", status_word, 8'hFF);

    // R2: special mode off, commands ignored
    drive_en_n = 1'b0;
    special_mode = 1'b0;
    waitc(6);
    send_cmd(5'd0);
    check_idle("R2 open cmd");
    send_cmd(5'b00100);
    check_idle("R2 short cmd");
    pulse(1'b0);
    check("R2 status", status_word, 8'hFF);
    drive_en_n = 1'b1;
    waitc(6);

    for (int p = 0; p < 32; p++)
      run_cmd(5'(p), 8'(p * 37 + 11));
    for (int b = 0; b < 8; b++)
      run_cmd((b % 2) ? 5'b00100 : 5'd0, 8'(1 << b));

    // R9: dropping special mode also ends detection
    special_mode = 1'b1;
    drive_en_n = 1'b0;
    waitc(6);
    send_cmd(5'd0);
    check("R3 det", det_type, 1);
    special_mode = 1'b0;
    waitc(6);
    check_idle("R9 mode drop");
    drive_en_n = 1'b1;

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule